// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block produces the word a host sees when it reads a flash bank while an internal program or erase runs there. It follows the operation through program, active erase, erase suspend and a sticky timeout-failure state. For every read strobe it decides whether to pass the array data through or to replace it with a status word. The word holds a data-complement polling bit, a run toggle bit, a pulse-limit failure bit and a sector toggle bit. The block also drives an active-low ready/busy line.

The program and erase algorithm is not modelled. Plain stimulus inputs stand in for it: start program (with sector and data), start erase (with a sector mask), suspend, resume, operation done, pulse limit exceeded and a software reset command. Addresses are given at sector granularity. The most significant bit of the sector index selects the bank. A read returns its result on `rd_data_o` one clock after the strobe, and the output holds until the next strobe.

Top module: `op_status_unit`

## Requirements
- R1: During a program, a read of any sector in the operation's bank returns bit 7 equal to the complement of bit 7 of the data being programmed. Bit 6 carries the run toggle, and every other bit reads 0.
- R2: The run toggle (bit 6) is cleared when an operation starts. It inverts after each status read in the operation's bank during program, active erase or failure, so the first status read shows 0.
- R3: The toggle bits change only on read strobes. Clock cycles without a read leave them unchanged.
- R4: During active erase, status reads in the operation's bank return bit 7 = 0. Reads of a sector whose bit is set in the erase mask (bit n = sector n) also return a sector toggle on bit 2 that inverts on each such read. Reads of unselected sectors return bit 2 = 0.
- R5: Suspend is accepted only during active erase. While suspended, reads of selected sectors return bit 7 = 1, a frozen bit 6 and a toggling bit 2, and reads of unselected sectors return array data. Resume returns to active erase with both toggles continuing from their held values.
- R6: Pulse limit during program or active erase enters failure. Status reads then set bit 5 = 1 and keep the other rules of the operation, with bit 7 = 0 for an erase. Done and suspend are ignored in failure, and only the reset command leaves it.
- R7: `rdy_bsy_no` is low during program, active erase and failure, and high when idle or suspended.
- R8: Done ends a program or active erase. Reads then return array data, including the true programmed data.
- R9: Reads of the other bank (sector index MSB differs from the operation's) and all reads while idle return array data unchanged.
- R10: Start commands are ignored unless idle, and suspend or resume outside their states has no effect. If both starts arrive together, program wins.
- R11: Asynchronous `rst_ni` low ends any operation at once. It sets `rdy_bsy_no` high and `rd_data_o` to 0 and clears both toggles.
- R12: `rd_data_o` takes the read result one clock after `rd_en_i` and holds it until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_prog_i | input | 1 | Start a program operation |
| start_erase_i | input | 1 | Start an erase operation |
| cmd_sect_i | input | SECT_W | Sector of the command; MSB gives the bank |
| cmd_data_i | input | DATA_W | Data being programmed |
| erase_mask_i | input | 2**SECT_W | Sectors selected for erase |
| suspend_i | input | 1 | Suspend request |
| resume_i | input | 1 | Resume request |
| done_i | input | 1 | Operation finished |
| limit_i | input | 1 | Pulse-count limit exceeded |
| reset_cmd_i | input | 1 | Software reset command |
| rd_en_i | input | 1 | Read strobe |
| rd_sect_i | input | SECT_W | Sector being read |
| arr_data_i | input | DATA_W | Array data at the read address |
| rd_data_o | output | DATA_W | Read result |
| rdy_bsy_no | output | 1 | Low while busy |

## Verification
The bench checks that a read of the other bank between two status reads leaves bit 6 unchanged. A design that toggled on every strobe would show the wrong phase on the next read. It checks that bit 6 freezes while suspended but bit 2 keeps toggling on selected sectors, and that both toggles continue correctly after resume. A design that kept toggling bit 6, or that reset the toggles on resume, would give off-by-one toggle values. It also checks that failure survives a done pulse and a suspend pulse, that starts arriving while busy leave the programmed data intact, and that idle clocks do not flip a toggle.

// File: rtl/op_status_pkg.sv
package op_status_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_PROG, ST_ERASE, ST_ESUSP, ST_FAIL} op_state_e;
  localparam int POLL_BIT = 7;
  localparam int RUN_TOG_BIT = 6;
  localparam int FAIL_BIT = 5;
  localparam int SECT_TOG_BIT = 2;
  localparam int NUM_TOG = 2;  // index 0: run toggle, index 1: sector toggle
endpackage

// File: rtl/opst_ctrl.sv
module opst_ctrl
  import op_status_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SECT_W = 4,
  localparam int NUM_SECT = 1 << SECT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_prog_i,
  input  logic                start_erase_i,
  input  logic [SECT_W-1:0]   cmd_sect_i,
  input  logic [DATA_W-1:0]   cmd_data_i,
  input  logic [NUM_SECT-1:0] erase_mask_i,
  input  logic                suspend_i,
  input  logic                resume_i,
  input  logic                done_i,
  input  logic                limit_i,
  input  logic                reset_cmd_i,
  output op_state_e           state_o,
  output logic                op_bank_o,
  output logic                op_erase_o,
  output logic [DATA_W-1:0]   prog_data_o,
  output logic [NUM_SECT-1:0] sel_mask_o,
  output logic                start_o
);
  op_state_e st_q, st_d;

  assign start_o = (st_q == ST_IDLE) && (start_prog_i || start_erase_i);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_prog_i) st_d = ST_PROG;
                else if (start_erase_i) st_d = ST_ERASE;
      ST_PROG:  if (limit_i) st_d = ST_FAIL;
                else if (done_i) st_d = ST_IDLE;
      ST_ERASE: if (limit_i) st_d = ST_FAIL;
                else if (suspend_i) st_d = ST_ESUSP;
                else if (done_i) st_d = ST_IDLE;
      ST_ESUSP: if (resume_i) st_d = ST_ERASE;
      ST_FAIL:  if (reset_cmd_i) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      op_bank_o   <= 1'b0;
      op_erase_o  <= 1'b0;
      prog_data_o <= '0;
      sel_mask_o  <= '0;
    end else begin
      st_q <= st_d;
      if (start_o) begin
        op_bank_o   <= cmd_sect_i[SECT_W-1];
        op_erase_o  <= !start_prog_i;
        prog_data_o <= start_prog_i ? cmd_data_i : '0;
        sel_mask_o  <= start_prog_i ? '0 : erase_mask_i;
      end
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/opst_toggle.sv
module opst_toggle #(
  parameter int NUM_TOG = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic [NUM_TOG-1:0] flip_i,
  output logic [NUM_TOG-1:0] tog_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_o <= '0;
    else if (clr_i) tog_o <= '0;
    else begin
      for (int i = 0; i < NUM_TOG; i++)
        if (flip_i[i]) tog_o[i] <= ~tog_o[i];
    end
  end
endmodule

// File: rtl/opst_rdmux.sv
module opst_rdmux
  import op_status_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SECT_W = 4,
  localparam int NUM_SECT = 1 << SECT_W
) (
  input  op_state_e           state_i,
  input  logic                op_bank_i,
  input  logic                op_erase_i,
  input  logic [DATA_W-1:0]   prog_data_i,
  input  logic [NUM_SECT-1:0] sel_mask_i,
  input  logic                rd_en_i,
  input  logic [SECT_W-1:0]   rd_sect_i,
  input  logic [DATA_W-1:0]   arr_data_i,
  input  logic [NUM_TOG-1:0]  tog_i,
  output logic [DATA_W-1:0]   word_o,
  output logic [NUM_TOG-1:0]  flip_o
);
  localparam logic [DATA_W-1:0] POLL_MASK = DATA_W'(1) << POLL_BIT;

  logic same_bank, sel;
  logic hit;
  logic [DATA_W-1:0] status;
  logic [NUM_TOG-1:0] flip;

  assign same_bank = (rd_sect_i[SECT_W-1] == op_bank_i);
  assign sel       = sel_mask_i[rd_sect_i];

  always_comb begin
    hit    = 1'b0;
    status = '0;
    flip   = '0;
    unique case (state_i)
      ST_PROG: if (same_bank) begin
        hit = 1'b1;
        status = ~prog_data_i & POLL_MASK;
        status[RUN_TOG_BIT] = tog_i[0];
        flip[0] = 1'b1;
      end
      ST_ERASE: if (same_bank) begin
        hit = 1'b1;
        status[RUN_TOG_BIT] = tog_i[0];
        flip[0] = 1'b1;
        if (sel) begin
          status[SECT_TOG_BIT] = tog_i[1];
          flip[1] = 1'b1;
        end
      end
      ST_ESUSP: if (same_bank && sel) begin
        hit = 1'b1;
        status[POLL_BIT] = 1'b1;
        status[RUN_TOG_BIT] = tog_i[0];  // frozen: never flipped here
        status[SECT_TOG_BIT] = tog_i[1];
        flip[1] = 1'b1;
      end
      ST_FAIL: if (same_bank) begin
        hit = 1'b1;
        status = op_erase_i ? '0 : (~prog_data_i & POLL_MASK);
        status[RUN_TOG_BIT] = tog_i[0];
        status[FAIL_BIT] = 1'b1;
        flip[0] = 1'b1;
        if (sel) begin
          status[SECT_TOG_BIT] = tog_i[1];
          flip[1] = 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign word_o = hit ? status : arr_data_i;
  assign flip_o = rd_en_i ? flip : '0;
endmodule

// File: rtl/op_status_unit.sv
module op_status_unit
  import op_status_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SECT_W = 4,
  localparam int NUM_SECT = 1 << SECT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_prog_i,
  input  logic                start_erase_i,
  input  logic [SECT_W-1:0]   cmd_sect_i,
  input  logic [DATA_W-1:0]   cmd_data_i,
  input  logic [NUM_SECT-1:0] erase_mask_i,
  input  logic                suspend_i,
  input  logic                resume_i,
  input  logic                done_i,
  input  logic                limit_i,
  input  logic                reset_cmd_i,
  input  logic                rd_en_i,
  input  logic [SECT_W-1:0]   rd_sect_i,
  input  logic [DATA_W-1:0]   arr_data_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic                rdy_bsy_no
);
  op_state_e           st;
  logic                op_bank, op_erase, start;
  logic [DATA_W-1:0]   prog_data, word;
  logic [NUM_SECT-1:0] sel_mask;
  logic [NUM_TOG-1:0]  tog, flip;

  opst_ctrl #(.DATA_W(DATA_W), .SECT_W(SECT_W)) u_ctrl (
    .clk_i, .rst_ni, .start_prog_i, .start_erase_i, .cmd_sect_i, .cmd_data_i,
    .erase_mask_i, .suspend_i, .resume_i, .done_i, .limit_i, .reset_cmd_i,
    .state_o(st), .op_bank_o(op_bank), .op_erase_o(op_erase),
    .prog_data_o(prog_data), .sel_mask_o(sel_mask), .start_o(start)
  );

  opst_toggle #(.NUM_TOG(NUM_TOG)) u_tog (
    .clk_i, .rst_ni, .clr_i(start), .flip_i(flip), .tog_o(tog)
  );

  opst_rdmux #(.DATA_W(DATA_W), .SECT_W(SECT_W)) u_mux (
    .state_i(st), .op_bank_i(op_bank), .op_erase_i(op_erase),
    .prog_data_i(prog_data), .sel_mask_i(sel_mask), .rd_en_i, .rd_sect_i,
    .arr_data_i, .tog_i(tog), .word_o(word), .flip_o(flip)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= word;
  end

  assign rdy_bsy_no = (st == ST_IDLE) || (st == ST_ESUSP);
endmodule

// File: rtl/op_status_unit_chk.sv
module op_status_unit_chk
  import op_status_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SECT_W = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input op_state_e          st,
  input logic               op_bank,
  input logic [DATA_W-1:0]  prog_data,
  input logic [NUM_TOG-1:0] tog,
  input logic               start_prog_i,
  input logic               start_erase_i,
  input logic               reset_cmd_i,
  input logic               rd_en_i,
  input logic [SECT_W-1:0]  rd_sect_i,
  input logic [DATA_W-1:0]  arr_data_i,
  input logic [DATA_W-1:0]  rd_data_o,
  input logic               rdy_bsy_no
);
  logic same_bank;
  assign same_bank = (rd_sect_i[SECT_W-1] == op_bank);

  AST_POLL_COMPLEMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_PROG && rd_en_i && same_bank) |=> rd_data_o[POLL_BIT] == ~$past(prog_data[POLL_BIT])); // R1
  AST_TOG_ON_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_en_i && !(st == ST_IDLE && (start_prog_i || start_erase_i))) |=> $stable(tog)); // R3
  AST_SUSP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_ESUSP) |=> $stable(tog[0])); // R5
  AST_FAIL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_FAIL && !reset_cmd_i) |=> st == ST_FAIL); // R6
  AST_FAIL_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_FAIL && rd_en_i && same_bank) |=> rd_data_o[FAIL_BIT]); // R6
  AST_BUSY_AFTER_PROG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE && start_prog_i) |=> !rdy_bsy_no); // R7
  AST_OTHER_BANK_ARRAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st != ST_IDLE && rd_en_i && !same_bank) |=> rd_data_o == $past(arr_data_i)); // R9
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o)); // R12
endmodule

bind op_status_unit op_status_unit_chk #(.DATA_W(DATA_W), .SECT_W(SECT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .st(st), .op_bank(op_bank), .prog_data(prog_data),
  .tog(tog), .start_prog_i(start_prog_i), .start_erase_i(start_erase_i),
  .reset_cmd_i(reset_cmd_i), .rd_en_i(rd_en_i), .rd_sect_i(rd_sect_i),
  .arr_data_i(arr_data_i), .rd_data_o(rd_data_o), .rdy_bsy_no(rdy_bsy_no)
);

// File: tb/op_status_unit_bench.sv
`timescale 1ns/1ps
module op_status_unit_bench;
  localparam int DATA_W = 32;
  localparam int SECT_W = 4;
  localparam int NUM_SECT = 1 << SECT_W;

  localparam logic [2:0] OP_RD = 3'd0, OP_PROG = 3'd1, OP_ERASE = 3'd2, OP_SUSP = 3'd3,
                         OP_RES = 3'd4, OP_DONE = 3'd5, OP_LIM = 3'd6, OP_RCMD = 3'd7;

  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  sect;
    logic [31:0] dat;   // array data for reads, program data, or erase mask
    logic        rdy;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 44;
  localparam vec_t VEC [NV] = '{
    '{OP_RD,    4'd0,  32'hA5A50001, 1'b1, 32'hA5A50001, 4'd9},  // R9 idle read
    '{OP_PROG,  4'd0,  32'h00000080, 1'b0, 32'h0, 4'd7},         // R7
    '{OP_RD,    4'd0,  32'h0000DEAD, 1'b0, 32'h00000000, 4'd1},  // R1
    '{OP_RD,    4'd0,  32'h0000DEAD, 1'b0, 32'h00000040, 4'd2},  // R2
    '{OP_RD,    4'd8,  32'h12345678, 1'b0, 32'h12345678, 4'd9},  // R9 other bank
    '{OP_RD,    4'd0,  32'h0000DEAD, 1'b0, 32'h00000000, 4'd2},  // R2 no toggle from other bank
    '{OP_DONE,  4'd0,  32'h0,        1'b1, 32'h0, 4'd8},         // R8
    '{OP_RD,    4'd0,  32'h00000080, 1'b1, 32'h00000080, 4'd8},  // R8 true data
    '{OP_PROG,  4'd1,  32'h00000000, 1'b0, 32'h0, 4'd7},
    '{OP_RD,    4'd1,  32'h0,        1'b0, 32'h00000080, 4'd1},
    '{OP_RD,    4'd1,  32'h0,        1'b0, 32'h000000C0, 4'd2},
    '{OP_ERASE, 4'd8,  32'h00000300, 1'b0, 32'h0, 4'd10},        // R10 ignored while busy
    '{OP_RD,    4'd1,  32'h0,        1'b0, 32'h00000080, 4'd10},
    '{OP_LIM,   4'd0,  32'h0,        1'b0, 32'h0, 4'd6},         // R6
    '{OP_RD,    4'd1,  32'h0,        1'b0, 32'h000000E0, 4'd6},
    '{OP_DONE,  4'd0,  32'h0,        1'b0, 32'h0, 4'd6},
    '{OP_RD,    4'd0,  32'h0,        1'b0, 32'h000000A0, 4'd6},
    '{OP_RCMD,  4'd0,  32'h0,        1'b1, 32'h0, 4'd6},
    '{OP_RD,    4'd1,  32'h00000055, 1'b1, 32'h00000055, 4'd6},
    '{OP_ERASE, 4'd8,  32'h00000300, 1'b0, 32'h0, 4'd7},
    '{OP_RD,    4'd8,  32'h0,        1'b0, 32'h00000000, 4'd4},  // R4 selected
    '{OP_RD,    4'd11, 32'h0,        1'b0, 32'h00000040, 4'd4},  // unselected
    '{OP_RD,    4'd9,  32'h0,        1'b0, 32'h00000004, 4'd4},
    '{OP_RD,    4'd4,  32'h00000BAD, 1'b0, 32'h00000BAD, 4'd9},
    '{OP_SUSP,  4'd0,  32'h0,        1'b1, 32'h0, 4'd5},         // R5
    '{OP_RD,    4'd8,  32'h0,        1'b1, 32'h000000C0, 4'd5},
    '{OP_RD,    4'd9,  32'h0,        1'b1, 32'h000000C4, 4'd5},
    '{OP_RD,    4'd11, 32'h00000777, 1'b1, 32'h00000777, 4'd5},
    '{OP_RES,   4'd0,  32'h0,        1'b0, 32'h0, 4'd5},
    '{OP_RD,    4'd11, 32'h0,        1'b0, 32'h00000040, 4'd5},
    '{OP_RD,    4'd8,  32'h0,        1'b0, 32'h00000000, 4'd4},
    '{OP_DONE,  4'd0,  32'h0,        1'b1, 32'h0, 4'd8},
    '{OP_RD,    4'd8,  32'hFFFFFFFF, 1'b1, 32'hFFFFFFFF, 4'd8},
    '{OP_RES,   4'd0,  32'h0,        1'b1, 32'h0, 4'd10},
    '{OP_SUSP,  4'd0,  32'h0,        1'b1, 32'h0, 4'd10},
    '{OP_ERASE, 4'd0,  32'h00000001, 1'b0, 32'h0, 4'd7},
    '{OP_LIM,   4'd0,  32'h0,        1'b0, 32'h0, 4'd6},
    '{OP_RD,    4'd0,  32'h0,        1'b0, 32'h00000020, 4'd6},
    '{OP_RD,    4'd0,  32'h0,        1'b0, 32'h00000064, 4'd6},
    '{OP_SUSP,  4'd0,  32'h0,        1'b0, 32'h0, 4'd6},
    '{OP_RCMD,  4'd0,  32'h0,        1'b1, 32'h0, 4'd6},
    '{OP_PROG,  4'd0,  32'h00000080, 1'b0, 32'h0, 4'd7},
    '{OP_SUSP,  4'd0,  32'h0,        1'b0, 32'h0, 4'd5},         // suspend ignored in program
    '{OP_RD,    4'd0,  32'h0,        1'b0, 32'h00000000, 4'd1}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_prog_i = 0, start_erase_i = 0, suspend_i = 0, resume_i = 0;
  logic done_i = 0, limit_i = 0, reset_cmd_i = 0, rd_en_i = 0;
  logic [SECT_W-1:0] cmd_sect_i = '0, rd_sect_i = '0;
  logic [DATA_W-1:0] cmd_data_i = '0, arr_data_i = '0;
  logic [NUM_SECT-1:0] erase_mask_i = '0;
  logic [DATA_W-1:0] rd_data_o;
  logic rdy_bsy_no;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  op_status_unit #(.DATA_W(DATA_W), .SECT_W(SECT_W)) u_op_status_unit (
    .clk_i(clk), .rst_ni, .start_prog_i, .start_erase_i, .cmd_sect_i, .cmd_data_i,
    .erase_mask_i, .suspend_i, .resume_i, .done_i, .limit_i, .reset_cmd_i,
    .rd_en_i, .rd_sect_i, .arr_data_i, .rd_data_o, .rdy_bsy_no
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clear_pulses();
    start_prog_i = 0; start_erase_i = 0; suspend_i = 0; resume_i = 0;
    done_i = 0; limit_i = 0; reset_cmd_i = 0; rd_en_i = 0;
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    case (v.op)
      OP_RD:    begin rd_en_i = 1; rd_sect_i = v.sect; arr_data_i = v.dat; end
      OP_PROG:  begin start_prog_i = 1; cmd_sect_i = v.sect; cmd_data_i = v.dat; end
      OP_ERASE: begin start_erase_i = 1; cmd_sect_i = v.sect; erase_mask_i = v.dat[NUM_SECT-1:0]; end
      OP_SUSP:  suspend_i = 1;
      OP_RES:   resume_i = 1;
      OP_DONE:  done_i = 1;
      OP_LIM:   limit_i = 1;
      default:  reset_cmd_i = 1;
    endcase
    @(negedge clk);
    clear_pulses();
    check($sformatf("R%0d rdy", v.req), {31'b0, rdy_bsy_no}, {31'b0, v.rdy});
    if (v.op == OP_RD) check($sformatf("R%0d data", v.req), rd_data_o, v.exp);
  endtask

  task automatic read_once(input logic [3:0] s, input logic [31:0] a);
    @(negedge clk);
    rd_en_i = 1; rd_sect_i = s; arr_data_i = a;
    @(negedge clk);
    rd_en_i = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=timeout exp=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset rdy", {31'b0, rdy_bsy_no}, 32'd1);
    check("R11 reset data", rd_data_o, 32'h0);
    rst_ni = 1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) run_vec(VEC[i]);
    // program on sector 0 still busy; last read showed bit 6 = 0
    repeat (5) @(negedge clk);
    read_once(4'd0, 32'h0);
    check("R3 idle clocks no toggle", rd_data_o, 32'h00000040);
    arr_data_i = 32'h13579BDF;
    repeat (4) @(negedge clk);
    check("R12 hold without strobe", rd_data_o, 32'h00000040);
    read_once(4'd8, 32'h2468ACE0);
    check("R12 one-cycle update", rd_data_o, 32'h2468ACE0);
    // hardware reset in mid-program
    @(negedge clk);
    rst_ni = 0;
    #1;
    check("R11 async rdy", {31'b0, rdy_bsy_no}, 32'd1);
    check("R11 async data", rd_data_o, 32'h0);
    @(negedge clk);
    rst_ni = 1;
    read_once(4'd0, 32'h00000099);
    check("R11 read mode after reset", rd_data_o, 32'h00000099);
    // simultaneous starts: program wins (R10)
    @(negedge clk);
    start_prog_i = 1; start_erase_i = 1; cmd_sect_i = 4'd2; cmd_data_i = 32'h0; erase_mask_i = 16'h0004;
    @(negedge clk);
    clear_pulses();
    read_once(4'd2, 32'h0);
    check("R10 program wins", rd_data_o, 32'h00000080);
    finish_run();
  end
endmodule